// File: doc/BRIEF.md
# AUX Channel Transaction Controller

This block stages one auxiliary-channel request that software has built in a small register file. When software sets the request bit, the block hands that request to a link-side agent over a parallel valid/ready handshake. It then waits for the agent's reply or for a programmable cycle limit to run out. When either happens it records the reply type, the received byte count, the error flags and up to 16 received bytes, and raises a done interrupt. Serial line coding, the pad, hot-plug debouncing and link training are left to other blocks.

Software writes the target address, the control word (command code and length) and, for writes, the payload. The payload is packed four bytes per 32-bit word, lowest byte first. Software then sets the request bit. A state machine steps through four states:
- `ST_IDLE`: setting the request bit moves it to `ST_ISSUE`.
- `ST_ISSUE`: it presents the request and moves to `ST_WAIT` when the agent accepts it. If the limit runs out first, it moves to `ST_FINISH`.
- `ST_WAIT`: a reply moves it to `ST_FINISH`. So does the limit running out.
- `ST_FINISH`: it sets the done flag and returns to `ST_IDLE`.

Word register map: 0 address, 1 control, 2 status, 3 interrupt enable, 4 interrupt status, 5 timeout limit, 8–11 transmit words, 12–15 receive words.

Top module: `auxch_ctrl`

## Requirements
- R1: After reset the status, interrupt status, interrupt enable and control registers read 0 (status bit 28 aside), the timeout register reads `TMO_RST` and `irq` is low.
- R2: Transmit word i drives `lnk_tx_data[32i+31:32i]`, and byte k of that word sits at bits 8k+7..8k of the word.
- R3: Control bits [3:0] hold length minus one and bits [11:8] hold the command code, which is passed to `lnk_cmd`. Command code 8 means address-only, and for it `lnk_len` is 0. For every other code `lnk_len` is the length field plus one.
- R4: Writing control with bit 16 set in `ST_IDLE` starts a transaction. `lnk_req_valid` is high from the next cycle, and control bits 16 (request) and 17 (busy) read 1.
- R5: While busy, writes to the address, control and timeout registers are ignored, and a second request bit starts nothing.
- R6: When a reply is accepted, status [4:0] takes the received count and [19:16] takes the reply type (0 native ACK, 1 native NACK, 2 native DEFER, 4 I2C NACK, 8 I2C DEFER). Reply error bits 0, 1 and 2 set sticky status bits 9 (receive error), 10 (sink status error) and 11 (no stop). Receive word i is filled from reply bytes 4i..4i+3, lowest byte first.
- R7: With a limit of N, a request with no reply ends once the timer has run N cycles. Timer cycles are those in `ST_ISSUE` and `ST_WAIT` without progress. At the end, status bit 8 is set, the count is set to 0 and done still follows.
- R8: Writing ones to status bits 11..8 clears those error flags. All other status fields are left unchanged.
- R9: Interrupt status bits are 0 done, 1 plug, 2 unplug and 3 sink IRQ. Each is set by its event and cleared by writing 1, and a set wins over a clear in the same cycle. `irq` is the OR of the status bits that are enabled in register 3.
- R10: The done bit is set on the cycle after `ST_FINISH`. At that point the request and busy bits read 0.
- R11: Status bit 28 follows `hpd_level` directly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_waddr | input | 4 | Register write word address |
| reg_wdata | input | 32 | Register write data |
| reg_raddr | input | 4 | Register read word address |
| reg_rdata | output | 32 | Register read data (combinational) |
| irq | output | 1 | Interrupt line |
| lnk_req_valid | output | 1 | Request presented to link agent |
| lnk_req_ready | input | 1 | Link agent accepts request |
| lnk_cmd | output | 4 | Command code |
| lnk_addr | output | ADDR_W | Target address |
| lnk_len | output | CNT_W | Payload byte count |
| lnk_tx_data | output | DATA_W | Transmit payload |
| lnk_rsp_valid | input | 1 | Reply strobe |
| lnk_rsp_type | input | 4 | Reply type code |
| lnk_rsp_count | input | CNT_W | Received byte count |
| lnk_rsp_err | input | 3 | Receive, sink status and no-stop errors |
| lnk_rsp_data | input | DATA_W | Received payload |
| hpd_level | input | 1 | Sink connected level |
| plug_evt | input | 1 | Plug event pulse |
| unplug_evt | input | 1 | Unplug event pulse |
| sink_irq_evt | input | 1 | Sink IRQ event pulse |

## Verification
The hardest situation to reach from the ports is the timeout path. The agent must accept the request and then stay silent, so that the expiry edge is the only thing that moves the machine forward. The bench programs a limit of 3, accepts the request at once and never replies. Its reference model counts the timer cycles independently and predicts the exact cycle in which done appears. A second hard case is an event and its clear landing in the same cycle. The bench raises `unplug_evt` in the same cycle as a write-one-to-clear of that bit.

// File: rtl/aux_pkg.sv
package aux_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ISSUE  = 2'd1,
        ST_WAIT   = 2'd2,
        ST_FINISH = 2'd3
    } aux_state_e;

    localparam logic [3:0] RA_ADDR  = 4'd0;
    localparam logic [3:0] RA_CTRL  = 4'd1;
    localparam logic [3:0] RA_STAT  = 4'd2;
    localparam logic [3:0] RA_INTEN = 4'd3;
    localparam logic [3:0] RA_INTST = 4'd4;
    localparam logic [3:0] RA_TMO   = 4'd5;

    localparam logic [3:0] CMD_ADDR_ONLY = 4'h8;
    localparam int         GO_BIT        = 16;
    localparam int         NUM_INT       = 4;
endpackage

// File: rtl/aux_fsm.sv
module aux_fsm
    import aux_pkg::*;
#(
    parameter int TMO_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             req_ready,
    input  logic             rsp_valid,
    input  logic [TMO_W-1:0] tmo,
    output aux_state_e       state,
    output logic             req_valid,
    output logic             capture,
    output logic             expire,
    output logic             finish,
    output logic             busy,
    output logic [TMO_W-1:0] tmr
);
    aux_state_e       state_q, state_d;
    logic [TMO_W-1:0] tmr_q;
    logic             stall;
    logic             at_lim;

    always_comb begin
        stall  = (state_q == ST_ISSUE && !req_ready) ||
                 (state_q == ST_WAIT && !rsp_valid);
        at_lim = (tmr_q == tmo);
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start) state_d = ST_ISSUE;
            ST_ISSUE:  if (req_ready) state_d = ST_WAIT;
                       else if (at_lim) state_d = ST_FINISH;
            ST_WAIT:   if (rsp_valid || at_lim) state_d = ST_FINISH;
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            tmr_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && start)
                tmr_q <= '0;
            else if (stall && !at_lim)
                tmr_q <= tmr_q + 1'b1;
        end
    end

    always_comb begin
        state     = state_q;
        tmr       = tmr_q;
        req_valid = (state_q == ST_ISSUE);
        capture   = (state_q == ST_WAIT) && rsp_valid;
        expire    = stall && at_lim;
        finish    = (state_q == ST_FINISH);
        busy      = (state_q != ST_IDLE);
    end
endmodule

// File: rtl/aux_irq.sv
module aux_irq #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr,
    input  logic [N-1:0] en,
    output logic [N-1:0] status,
    output logic         irq
);
    logic [N-1:0] st_q;

    for (genvar i = 0; i < N; i++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) st_q[i] <= 1'b0;
            else        st_q[i] <= set[i] | (st_q[i] & ~clr[i]);
        end
    end

    assign status = st_q;
    assign irq    = |(st_q & en);
endmodule

// File: rtl/aux_buf.sv
module aux_buf #(
    parameter int NWORDS = 4,
    localparam int IDX_W  = $clog2(NWORDS),
    localparam int DATA_W = NWORDS * 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_we,
    input  logic [IDX_W-1:0]  tx_idx,
    input  logic [31:0]       wdata,
    input  logic              rx_cap,
    input  logic [DATA_W-1:0] rx_in,
    output logic [DATA_W-1:0] tx_flat,
    output logic [DATA_W-1:0] rx_flat
);
    for (genvar w = 0; w < NWORDS; w++) begin : g_word
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                tx_flat[w*32 +: 32] <= '0;
                rx_flat[w*32 +: 32] <= '0;
            end else begin
                if (tx_we && tx_idx == IDX_W'(w))
                    tx_flat[w*32 +: 32] <= wdata;
                if (rx_cap)
                    rx_flat[w*32 +: 32] <= rx_in[w*32 +: 32];
            end
        end
    end
endmodule

// File: rtl/auxch_ctrl.sv
module auxch_ctrl
    import aux_pkg::*;
#(
    parameter int              ADDR_W  = 20,
    parameter int              NWORDS  = 4,
    parameter int              TMO_W   = 16,
    parameter logic [TMO_W-1:0] TMO_RST = 16'd1000,
    localparam int NBYTES = NWORDS * 4,
    localparam int DATA_W = NWORDS * 32,
    localparam int CNT_W  = $clog2(NBYTES + 1),
    localparam int LEN_W  = $clog2(NBYTES),
    localparam int IDX_W  = $clog2(NWORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [3:0]        reg_waddr,
    input  logic [31:0]       reg_wdata,
    input  logic [3:0]        reg_raddr,
    output logic [31:0]       reg_rdata,
    output logic              irq,
    output logic              lnk_req_valid,
    input  logic              lnk_req_ready,
    output logic [3:0]        lnk_cmd,
    output logic [ADDR_W-1:0] lnk_addr,
    output logic [CNT_W-1:0]  lnk_len,
    output logic [DATA_W-1:0] lnk_tx_data,
    input  logic              lnk_rsp_valid,
    input  logic [3:0]        lnk_rsp_type,
    input  logic [CNT_W-1:0]  lnk_rsp_count,
    input  logic [2:0]        lnk_rsp_err,
    input  logic [DATA_W-1:0] lnk_rsp_data,
    input  logic              hpd_level,
    input  logic              plug_evt,
    input  logic              unplug_evt,
    input  logic              sink_irq_evt
);
    aux_state_e        fsm_state;
    logic              busy, capture, expire, finish, start;
    logic [TMO_W-1:0]  tmr, tmo_q;
    logic [ADDR_W-1:0] addr_q;
    logic [LEN_W-1:0]  lenm1_q;
    logic [3:0]        cmd_q, type_q, err_q, err_clr;
    logic [CNT_W-1:0]  cnt_q;
    logic              go_q;
    logic [NUM_INT-1:0] int_en_q, int_st, int_set, int_clr;
    logic [DATA_W-1:0] rx_flat;
    logic              wr_cfg;

    always_comb begin
        wr_cfg  = reg_wr && !busy;
        start   = wr_cfg && reg_waddr == RA_CTRL && reg_wdata[GO_BIT];
        err_clr = (reg_wr && reg_waddr == RA_STAT) ? reg_wdata[11:8] : 4'h0;
        int_clr = (reg_wr && reg_waddr == RA_INTST) ? reg_wdata[NUM_INT-1:0] : '0;
        int_set = {sink_irq_evt, unplug_evt, plug_evt, finish};
    end

    aux_fsm #(.TMO_W(TMO_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .start(start),
        .req_ready(lnk_req_ready), .rsp_valid(lnk_rsp_valid), .tmo(tmo_q),
        .state(fsm_state), .req_valid(lnk_req_valid), .capture(capture),
        .expire(expire), .finish(finish), .busy(busy), .tmr(tmr)
    );

    aux_irq #(.N(NUM_INT)) u_irq (
        .clk(clk), .rst_n(rst_n), .set(int_set), .clr(int_clr),
        .en(int_en_q), .status(int_st), .irq(irq)
    );

    aux_buf #(.NWORDS(NWORDS)) u_buf (
        .clk(clk), .rst_n(rst_n),
        .tx_we(reg_wr && reg_waddr[3:2] == 2'b10),
        .tx_idx(reg_waddr[IDX_W-1:0]), .wdata(reg_wdata),
        .rx_cap(capture), .rx_in(lnk_rsp_data),
        .tx_flat(lnk_tx_data), .rx_flat(rx_flat)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q   <= '0;
            lenm1_q  <= '0;
            cmd_q    <= '0;
            go_q     <= 1'b0;
            tmo_q    <= TMO_RST;
            int_en_q <= '0;
            cnt_q    <= '0;
            type_q   <= '0;
            err_q    <= '0;
        end else begin
            if (wr_cfg && reg_waddr == RA_ADDR) addr_q <= reg_wdata[ADDR_W-1:0];
            if (wr_cfg && reg_waddr == RA_CTRL) begin
                lenm1_q <= reg_wdata[LEN_W-1:0];
                cmd_q   <= reg_wdata[11:8];
            end
            if (wr_cfg && reg_waddr == RA_TMO) tmo_q <= reg_wdata[TMO_W-1:0];
            if (reg_wr && reg_waddr == RA_INTEN) int_en_q <= reg_wdata[NUM_INT-1:0];
            if (start)       go_q <= 1'b1;
            else if (finish) go_q <= 1'b0;
            if (capture) begin
                cnt_q  <= lnk_rsp_count;
                type_q <= lnk_rsp_type;
            end else if (expire) begin
                cnt_q  <= '0;
            end
            err_q <= (err_q & ~err_clr) |
                     {capture ? lnk_rsp_err : 3'b000, expire};
        end
    end

    always_comb begin
        lnk_cmd  = cmd_q;
        lnk_addr = addr_q;
        lnk_len  = (cmd_q == CMD_ADDR_ONLY) ? '0 : CNT_W'(lenm1_q) + 1'b1;
    end

    always_comb begin
        reg_rdata = '0;
        unique case (reg_raddr)
            RA_ADDR:  reg_rdata = 32'(addr_q);
            RA_CTRL:  begin
                reg_rdata[LEN_W-1:0] = lenm1_q;
                reg_rdata[11:8]      = cmd_q;
                reg_rdata[GO_BIT]    = go_q;
                reg_rdata[GO_BIT+1]  = busy;
            end
            RA_STAT:  begin
                reg_rdata[CNT_W-1:0] = cnt_q;
                reg_rdata[11:8]      = err_q;
                reg_rdata[19:16]     = type_q;
                reg_rdata[28]        = hpd_level;
            end
            RA_INTEN: reg_rdata = 32'(int_en_q);
            RA_INTST: reg_rdata = 32'(int_st);
            RA_TMO:   reg_rdata = 32'(tmo_q);
            4'd8, 4'd9, 4'd10, 4'd11:
                reg_rdata = lnk_tx_data[reg_raddr[IDX_W-1:0]*32 +: 32];
            4'd12, 4'd13, 4'd14, 4'd15:
                reg_rdata = rx_flat[reg_raddr[IDX_W-1:0]*32 +: 32];
            default:  reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/aux_chk.sv
module aux_chk #(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 128,
    parameter int CNT_W  = 5,
    parameter int TMO_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic [1:0]        state,
    input logic              busy,
    input logic [TMO_W-1:0]  tmr,
    input logic [TMO_W-1:0]  tmo,
    input logic              done,
    input logic              lnk_req_valid,
    input logic              lnk_req_ready,
    input logic [3:0]        lnk_cmd,
    input logic [CNT_W-1:0]  lnk_len,
    input logic [ADDR_W-1:0] lnk_addr,
    input logic [DATA_W-1:0] lnk_tx_data
);
    a_r2_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        (lnk_req_valid && !lnk_req_ready && tmr != tmo) |=>
            (lnk_req_valid && $stable(lnk_tx_data) && $stable(lnk_cmd) && $stable(lnk_len)));

    a_r4_start_from_write: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (lnk_req_valid && $past(reg_wr)));

    a_r5_addr_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (!busy || $stable(lnk_addr)));

    a_r7_timer_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (tmr <= tmo));

    a_r10_done_after_finish: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> (!busy && $past(state) == 2'd3));
endmodule

bind auxch_ctrl aux_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .TMO_W(TMO_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .state(fsm_state),
    .busy(busy), .tmr(tmr), .tmo(tmo_q), .done(int_st[0]),
    .lnk_req_valid(lnk_req_valid), .lnk_req_ready(lnk_req_ready),
    .lnk_cmd(lnk_cmd), .lnk_len(lnk_len), .lnk_addr(lnk_addr),
    .lnk_tx_data(lnk_tx_data)
);

// File: tb/auxch_ctrl_bench.sv
module auxch_ctrl_bench;
    localparam logic [31:0] H  = 32'h1000_0000;
    localparam logic [31:0] GO = 32'h0001_0000;

    logic clk = 0, rst_n = 0;
    logic reg_wr = 0;
    logic [3:0] reg_waddr = 0, reg_raddr = 0;
    logic [31:0] reg_wdata = 0, reg_rdata;
    logic irq, lnk_req_valid, lnk_req_ready = 0;
    logic [3:0] lnk_cmd;
    logic [19:0] lnk_addr;
    logic [4:0] lnk_len;
    logic [127:0] lnk_tx_data;
    logic lnk_rsp_valid = 0;
    logic [3:0] lnk_rsp_type = 0;
    logic [4:0] lnk_rsp_count = 0;
    logic [2:0] lnk_rsp_err = 0;
    logic [127:0] lnk_rsp_data = 0;
    logic hpd_level = 0, plug_evt = 0, unplug_evt = 0, sink_irq_evt = 0;

    int nchk = 0, nfail = 0;
    bit finished = 0;

    // behavioural reference model
    int ms = 0, mt = 0, mtmo = 40;
    logic [3:0] mint = 0, men = 0, mclr, mset;

    always #10 clk = ~clk;

    auxch_ctrl #(.TMO_RST(16'd40)) u_auxch_ctrl (.*);

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1; reg_waddr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 0;
    endtask

    task automatic rd(input logic [3:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        reg_raddr = a;
        #2;
        chk(tag, reg_rdata, exp);
    endtask

    task automatic reply(input logic [3:0] t, input logic [4:0] c,
                         input logic [2:0] e, input logic [127:0] d);
        lnk_req_ready = 1;
        @(negedge clk);
        lnk_req_ready = 0;
        lnk_rsp_valid = 1; lnk_rsp_type = t; lnk_rsp_count = c;
        lnk_rsp_err = e; lnk_rsp_data = d;
        @(negedge clk);
        lnk_rsp_valid = 0;
        @(negedge clk);
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            ms = 0; mt = 0; mtmo = 40; mint = 0; men = 0;
        end else begin
            mclr = (reg_wr && reg_waddr == 4'd4) ? reg_wdata[3:0] : 4'h0;
            mset = {sink_irq_evt, unplug_evt, plug_evt, ms == 3};
            if (reg_wr && reg_waddr == 4'd3) men = reg_wdata[3:0];
            mint = (mint & ~mclr) | mset;
            case (ms)
                0: if (reg_wr && reg_waddr == 4'd1 && reg_wdata[16]) begin ms = 1; mt = 0; end
                   else if (reg_wr && reg_waddr == 4'd5) mtmo = int'(reg_wdata[15:0]);
                1: if (lnk_req_ready) ms = 2; else if (mt == mtmo) ms = 3; else mt++;
                2: if (lnk_rsp_valid) ms = 3; else if (mt == mtmo) ms = 3; else mt++;
                default: ms = 0;
            endcase
        end
    end

    always @(posedge clk) begin
        #5;
        if (rst_n && !finished) begin
            chk("R4 req_valid per cycle", 32'(lnk_req_valid), 32'(ms == 1));
            chk("R9 irq per cycle", 32'(irq), 32'(|(mint & men)));
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            nfail++;
            nchk++;
            $display("FAIL watchdog actual=hung expected=done");
            finished = 1;
            $display("[TB] %0d tests run, %0d failed", nchk, nfail);
            $finish;
        end
    end

    initial begin
        logic [127:0] rdat;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        rd(4'd2, 32'h0, "R1 status");
        rd(4'd4, 32'h0, "R1 int status");
        rd(4'd3, 32'h0, "R1 int enable");
        rd(4'd1, 32'h0, "R1 control");
        rd(4'd5, 32'd40, "R1 timeout");
        chk("R1 irq", 32'(irq), 32'h0);
        // R11 hot-plug level
        hpd_level = 1;
        rd(4'd2, H, "R11 hpd high");
        hpd_level = 0;
        rd(4'd2, 32'h0, "R11 hpd low");
        hpd_level = 1;
        wr(4'd3, 32'hF);

        // native write of 6 bytes
        wr(4'd8, 32'h44332211);
        wr(4'd9, 32'h00006655);
        wr(4'd0, 32'h12345);
        wr(4'd1, GO | 32'h0905);
        #1;
        chk("R3 cmd", 32'(lnk_cmd), 32'h9);
        chk("R3 len", 32'(lnk_len), 32'd6);
        chk("R4 addr", 32'(lnk_addr), 32'h12345);
        chk("R2 byte0", 32'(lnk_tx_data[7:0]), 32'h11);
        chk("R2 byte5", 32'(lnk_tx_data[47:40]), 32'h66);
        chk("R2 word1", lnk_tx_data[63:32], 32'h00006655);
        rd(4'd1, 32'h0003_0905, "R4 busy and go");
        wr(4'd1, GO | 32'h0A02);
        wr(4'd0, 32'h0BEEF);
        #1;
        chk("R5 cmd kept", 32'(lnk_cmd), 32'h9);
        chk("R5 len kept", 32'(lnk_len), 32'd6);
        chk("R5 addr kept", 32'(lnk_addr), 32'h12345);
        reply(4'h0, 5'd0, 3'b000, 128'h0);
        rd(4'd4, 32'h1, "R10 done set");
        rd(4'd1, 32'h0000_0905, "R10 go and busy clear");
        rd(4'd2, H, "R6 ack status");
        chk("R5 no second request", 32'(lnk_req_valid), 32'h0);
        wr(4'd4, 32'h1);
        rd(4'd4, 32'h0, "R9 done cleared");

        // native read of 16 bytes
        wr(4'd0, 32'h00400);
        wr(4'd1, GO | 32'h0A0F);
        #1;
        chk("R3 len 16", 32'(lnk_len), 32'd16);
        for (int k = 0; k < 16; k++) rdat[8*k +: 8] = 8'hA0 + 8'(k);
        reply(4'h0, 5'd16, 3'b000, rdat);
        rd(4'd12, 32'hA3A2A1A0, "R6 rx word0");
        rd(4'd15, 32'hAFAEADAC, "R6 rx word3");
        rd(4'd2, H | 32'd16, "R6 count 16");
        wr(4'd4, 32'h1);

        // I2C address-only with errors
        wr(4'd1, GO | 32'h0807);
        #1;
        chk("R3 address-only len", 32'(lnk_len), 32'd0);
        reply(4'h4, 5'd0, 3'b101, 128'h0);
        rd(4'd2, H | 32'h0004_0A00, "R6 i2c nack with errors");
        // R8 write-one-to-clear
        wr(4'd2, 32'h200);
        rd(4'd2, H | 32'h0004_0800, "R8 partial clear");
        wr(4'd2, 32'hF00);
        rd(4'd2, H | 32'h0004_0000, "R8 full clear");
        wr(4'd4, 32'h1);

        // R7 timeout
        wr(4'd5, 32'd3);
        rd(4'd5, 32'd3, "R7 limit");
        wr(4'd1, GO | 32'h0100);
        lnk_req_ready = 1;
        @(negedge clk);
        lnk_req_ready = 0;
        repeat (3) @(negedge clk);
        rd(4'd1, 32'h0003_0100, "R7 still busy");
        @(negedge clk);
        rd(4'd2, H | 32'h0004_0100, "R7 timeout flag");
        rd(4'd4, 32'h1, "R7 done after timeout");
        wr(4'd4, 32'h1);

        // R9 interrupts
        @(negedge clk); plug_evt = 1;
        @(negedge clk); plug_evt = 0;
        rd(4'd4, 32'h2, "R9 plug");
        chk("R9 irq enabled", 32'(irq), 32'h1);
        wr(4'd3, 32'h0);
        #1;
        chk("R9 irq masked", 32'(irq), 32'h0);
        @(negedge clk);
        reg_wr = 1; reg_waddr = 4'd4; reg_wdata = 32'h6; unplug_evt = 1;
        @(negedge clk);
        reg_wr = 0; unplug_evt = 0;
        rd(4'd4, 32'h4, "R9 set beats clear");
        @(negedge clk); sink_irq_evt = 1;
        @(negedge clk); sink_irq_evt = 0;
        rd(4'd4, 32'hC, "R9 sink irq");
        wr(4'd3, 32'h8);
        #1;
        chk("R9 irq sink enabled", 32'(irq), 32'h1);

        repeat (2) @(negedge clk);
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", nchk, nfail);
        $finish;
    end
endmodule